// File: doc/BRIEF.md
# Mode-Gated Interrupt Aggregator

This block merges three groups of event sources into a single interrupt pin: four transmit sources, eight receive sources split across two receive channels (A and B), and one wake source. Each source has its own sticky status bit, set by a one-cycle event pulse. Each source also has its own enable bit. Software reaches the enable, status and configuration registers through a plain register bus with separate read and write strobes. Reading a status register returns its contents and clears them. Status bits are recorded whether or not the matching enable is set, so firmware can poll them and leave the pin unused.

The radio mode gates whole groups. While the mode input selects transmit, no receive source can reach the pin. While it selects receive, no transmit source can reach the pin. The enable registers keep their contents through every mode change. When the symbol-mode input selects one of the single-channel modes, the channel B receive sources are held silent: their events are discarded and their enables have no effect. The wake group is never gated by mode.

The pin is driven only while the interrupt is asserted. The configuration register picks the polarity. Active-low behaves as an open-drain output and active-high behaves as an open-source output. The output-enable port tells the pad when to drive.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset every enable bit, every status bit and the polarity bit are 0. The pin is undriven (`irq_oe`=0) and `irq_level` rests at 1, the idle level for active-low.
- R2: An event pulse sets its status bit on the next clock edge whether or not the source is enabled. The bit stays set until its status register is read. The pin asserts only if the source's enable bit is also set.
- R3: While `mode_tx`=1 the receive status bits cannot assert the pin, and while `mode_tx`=0 the transmit status bits cannot assert it. In both cases the status bits are still recorded.
- R4: Enable register contents do not change when `mode_tx` or `sym_mode` changes. Only a bus write changes them.
- R5: A read of a status register returns the contents held before the read and clears every bit of that register. A bit whose event pulse arrives in the same cycle as the read stays set.
- R6: The wake enable is bit 0 at address 0x1C and the wake status is bit 0 at address 0x1D. Reading 0x1D clears the wake status. Wake is never gated by `mode_tx`.
- R7: When `sym_mode` is 2'b00 (64 chips/bit) or 2'b01 (32 chips/bit double rate), channel B receive events set no status bit and channel B sources never assert the pin, even when enabled. When `sym_mode[1]`=1, both channels are active.
- R8: Configuration bit 0 at address 0x05 is the polarity, where 1 means active-high. `irq_oe` is 1 exactly while some source is status AND enable AND gate. While `irq_oe`=1, `irq_level` equals the polarity bit. While `irq_oe`=0, `irq_level` is its inverse.
- R9: The register map is as follows. The receive enable register is at 0x07 and the receive status register at 0x08, with bits [3:0] for channel A and bits [7:4] for channel B. The transmit enable register is at 0x0D and the transmit status register at 0x0E, using bits [3:0]. Writes to status addresses are ignored. Unused bits and unmapped addresses read 0.
- R10: `rd_data` is updated on the clock edge that samples `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tx | input | 1 | 1 = transmit mode, 0 = receive mode |
| sym_mode | input | 2 | Symbol mode; bit 1 = 0 selects a single-channel mode |
| tx_evt | input | 4 | Transmit event pulses |
| rx_evt | input | 8 | Receive event pulses, [3:0] channel A, [7:4] channel B |
| wake_evt | input | 1 | Wake event pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| irq_level | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench uses the default build: four transmit sources, four sources per receive channel, and 8-bit address and data. At this size it can step through every one of the thirteen sources under every combination of transmit/receive mode, the three distinct symbol-mode classes, both polarities, and enable on or off. For each case the expected pin level, output-enable, status word and post-read clear are computed arithmetically. Directed cases then cover enable retention across mode changes, an event that collides with a read, ignored writes to status registers, and read-data hold.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam logic [7:0] ADR_CFG      = 8'h05;
  localparam logic [7:0] ADR_RX_EN    = 8'h07;
  localparam logic [7:0] ADR_RX_STAT  = 8'h08;
  localparam logic [7:0] ADR_TX_EN    = 8'h0D;
  localparam logic [7:0] ADR_TX_STAT  = 8'h0E;
  localparam logic [7:0] ADR_WK_EN    = 8'h1C;
  localparam logic [7:0] ADR_WK_STAT  = 8'h1D;

  typedef enum logic [1:0] {
    SYM_64       = 2'b00,
    SYM_32_DDR   = 2'b01,
    SYM_32_DUAL  = 2'b10,
    SYM_32_DUAL2 = 2'b11
  } sym_mode_e;

  // Channel B of the receiver exists only in the dual-channel modes.
  function automatic logic chan_b_active(input logic [1:0] sym);
    return sym[1];
  endfunction

endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_i[i])   bit_q <= 1'b1;
      else if (clr_i)      bit_q <= 1'b0;
    end

    assign stat_o[i] = bit_q;

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> stat_o[i]); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[i] && !clr_i) |=> stat_o[i]); // R2
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !stat_o[i]); // R5
  end

endmodule

// File: rtl/evt_reg_ctl.sv
module evt_reg_ctl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TX_N   = 4,
  parameter int RX_N   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TX_N-1:0]   tx_stat,
  input  logic [RX_N-1:0]   rx_stat,
  input  logic              wake_stat,
  output logic [TX_N-1:0]   tx_en,
  output logic [RX_N-1:0]   rx_en,
  output logic              wake_en,
  output logic              pol_high,
  output logic              tx_clr,
  output logic              rx_clr,
  output logic              wake_clr,
  output logic [DATA_W-1:0] rd_data
);

  logic hit_cfg, hit_rx_en, hit_rx_st, hit_tx_en, hit_tx_st, hit_wk_en, hit_wk_st;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wr;

  assign hit_cfg   = (addr == ADDR_W'(ADR_CFG));
  assign hit_rx_en = (addr == ADDR_W'(ADR_RX_EN));
  assign hit_rx_st = (addr == ADDR_W'(ADR_RX_STAT));
  assign hit_tx_en = (addr == ADDR_W'(ADR_TX_EN));
  assign hit_tx_st = (addr == ADDR_W'(ADR_TX_STAT));
  assign hit_wk_en = (addr == ADDR_W'(ADR_WK_EN));
  assign hit_wk_st = (addr == ADDR_W'(ADR_WK_STAT));
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en    <= '0;
      rx_en    <= '0;
      wake_en  <= 1'b0;
      pol_high <= 1'b0;
    end else if (wr_en) begin
      if (hit_cfg)   pol_high <= wr_data[0];
      if (hit_rx_en) rx_en    <= wr_data[RX_N-1:0];
      if (hit_tx_en) tx_en    <= wr_data[TX_N-1:0];
      if (hit_wk_en) wake_en  <= wr_data[0];
    end
  end

  assign tx_clr   = rd_en && hit_tx_st;
  assign rx_clr   = rd_en && hit_rx_st;
  assign wake_clr = rd_en && hit_wk_st;

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit_cfg:   rd_mux = DATA_W'(pol_high);
      hit_rx_en: rd_mux = DATA_W'(rx_en);
      hit_rx_st: rd_mux = DATA_W'(rx_stat);
      hit_tx_en: rd_mux = DATA_W'(tx_en);
      hit_tx_st: rd_mux = DATA_W'(tx_stat);
      hit_wk_en: rd_mux = DATA_W'(wake_en);
      hit_wk_st: rd_mux = DATA_W'(wake_stat);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_EN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tx_en) && $stable(rx_en) && $stable(wake_en))); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10

endmodule

// File: rtl/evt_irq_pin.sv
module evt_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic pol_high,
  output logic irq_level,
  output logic irq_oe
);

  // Open-drain (active-low) or open-source (active-high): drive only when asserted.
  assign irq_oe    = want;
  assign irq_level = want ? pol_high : ~pol_high;

  AST_DRIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (irq_level == pol_high)); // R8

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int TX_N     = 4,
  parameter int RX_PER_CH = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_tx,
  input  logic [1:0]           sym_mode,
  input  logic [TX_N-1:0]      tx_evt,
  input  logic [2*RX_PER_CH-1:0] rx_evt,
  input  logic                 wake_evt,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_level,
  output logic                 irq_oe
);

  localparam int RX_N = 2 * RX_PER_CH;

  logic [TX_N-1:0] tx_stat, tx_en;
  logic [RX_N-1:0] rx_stat, rx_en, rx_set, rx_chan_mask;
  logic            wake_stat, wake_en, pol_high;
  logic            tx_clr, rx_clr, wake_clr;
  logic            chan_b_on, tx_hit, rx_hit, wake_hit, want;

  assign chan_b_on = chan_b_active(sym_mode);

  for (genvar c = 0; c < 2; c++) begin : g_chan
    if (c == 0) begin : g_a
      assign rx_chan_mask[RX_PER_CH-1:0] = '1;
    end else begin : g_b
      assign rx_chan_mask[RX_N-1:RX_PER_CH] = {RX_PER_CH{chan_b_on}};
    end
  end

  assign rx_set = rx_evt & rx_chan_mask;

  evt_reg_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_N(TX_N), .RX_N(RX_N)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .tx_stat(tx_stat), .rx_stat(rx_stat), .wake_stat(wake_stat),
    .tx_en(tx_en), .rx_en(rx_en), .wake_en(wake_en), .pol_high(pol_high),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .wake_clr(wake_clr), .rd_data(rd_data)
  );

  evt_sticky_bank #(.W(TX_N)) u_tx_stat (
    .clk(clk), .rst_n(rst_n), .set_i(tx_evt), .clr_i(tx_clr), .stat_o(tx_stat)
  );

  evt_sticky_bank #(.W(RX_N)) u_rx_stat (
    .clk(clk), .rst_n(rst_n), .set_i(rx_set), .clr_i(rx_clr), .stat_o(rx_stat)
  );

  evt_sticky_bank #(.W(1)) u_wk_stat (
    .clk(clk), .rst_n(rst_n), .set_i(wake_evt), .clr_i(wake_clr), .stat_o(wake_stat)
  );

  assign tx_hit   = mode_tx  && |(tx_stat & tx_en);
  assign rx_hit   = !mode_tx && |(rx_stat & rx_en & rx_chan_mask);
  assign wake_hit = wake_stat && wake_en;
  assign want     = tx_hit || rx_hit || wake_hit;

  evt_irq_pin u_pin (
    .clk(clk), .rst_n(rst_n), .want(want), .pol_high(pol_high),
    .irq_level(irq_level), .irq_oe(irq_oe)
  );

  AST_RX_MASKED_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tx && !(wake_stat && wake_en) && ((tx_stat & tx_en) == '0)) |-> !irq_oe); // R3
  AST_TX_MASKED_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_tx && !(wake_stat && wake_en) && ((rx_stat & rx_en) == '0)) |-> !irq_oe); // R3
  AST_CHB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_mode[1] |=> ((rx_stat[RX_N-1:RX_PER_CH] & ~$past(rx_stat[RX_N-1:RX_PER_CH])) == '0)); // R7
  AST_WAKE_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_stat && wake_en) |-> irq_oe); // R6

endmodule

// File: tb/evt_irq_hub_tb.sv
`timescale 1ns/1ps
module evt_irq_hub_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_tx = 1'b0;
  logic [1:0] sym_mode = 2'b10;
  logic [3:0] tx_evt = '0;
  logic [7:0] rx_evt = '0;
  logic       wake_evt = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_level, irq_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  evt_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .sym_mode(sym_mode),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .wake_evt(wake_evt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_level(irq_level), .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  // source index: 0..3 transmit, 4..11 receive (4..7 A, 8..11 B), 12 wake
  task automatic pulse(input int s);
    @(negedge clk);
    if (s < 4)       tx_evt[s] = 1'b1;
    else if (s < 12) rx_evt[s-4] = 1'b1;
    else             wake_evt = 1'b1;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; wake_evt = 1'b0;
  endtask

  task automatic run_case(input int s, input bit mtx, input logic [1:0] sym,
                          input bit pol, input bit en);
    logic [7:0] d, st_addr, exp_st;
    bit recorded, gate, asserted;
    string tag;
    @(negedge clk); mode_tx = mtx; sym_mode = sym;
    bus_wr(8'h05, {7'd0, pol});
    bus_wr(8'h0D, en ? 8'h0F : 8'h00);
    bus_wr(8'h07, en ? 8'hFF : 8'h00);
    bus_wr(8'h1C, {7'd0, en});
    pulse(s);
    recorded = !(s >= 8 && s < 12 && sym[1] == 1'b0);
    if (s < 4)       begin gate = mtx;  st_addr = 8'h0E; exp_st = 8'(1 << s);      tag = "R3"; end
    else if (s < 12) begin gate = !mtx; st_addr = 8'h08; exp_st = 8'(1 << (s-4));  tag = (s >= 8 && !sym[1]) ? "R7" : "R3"; end
    else             begin gate = 1'b1; st_addr = 8'h1D; exp_st = 8'h01;           tag = "R6"; end
    if (!recorded) exp_st = 8'h00;
    asserted = recorded && en && gate;
    check({tag, " oe"}, irq_oe, asserted);
    check("R8 level", irq_level, asserted ? pol : !pol);
    bus_rd(st_addr, d);
    check({tag, " R2 status"}, d, exp_st);
    check("R5 clear oe", irq_oe, 0);
    bus_rd(st_addr, d);
    check("R5 cleared", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", irq_oe, 0);
    check("R1 level", irq_level, 1);
    foreach (evt_irq_pkg::ADR_CFG[i]) ; // no-op keeps package referenced
    bus_rd(8'h05, d); check("R1 cfg", d, 0);
    bus_rd(8'h07, d); check("R1 rx_en", d, 0);
    bus_rd(8'h08, d); check("R1 rx_st", d, 0);
    bus_rd(8'h0D, d); check("R1 tx_en", d, 0);
    bus_rd(8'h0E, d); check("R1 tx_st", d, 0);
    bus_rd(8'h1C, d); check("R1 wk_en", d, 0);
    bus_rd(8'h1D, d); check("R1 wk_st", d, 0);

    // Sweep every source over mode, symbol class, polarity, enable
    for (int s = 0; s < 13; s++)
      for (int m = 0; m < 2; m++)
        for (int y = 0; y < 3; y++)
          for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++)
              run_case(s, m[0], (y == 0) ? 2'b00 : (y == 1) ? 2'b01 : 2'b10, p[0], e[0]);

    // R4 enables kept across mode changes
    bus_wr(8'h07, 8'hA5); bus_wr(8'h0D, 8'h09); bus_wr(8'h1C, 8'h01);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); mode_tx = k[0]; sym_mode = k[1:0];
    end
    bus_rd(8'h07, d); check("R4 rx_en", d, 8'hA5);
    bus_rd(8'h0D, d); check("R4 tx_en", d, 8'h09);
    bus_rd(8'h1C, d); check("R4 wk_en", d, 8'h01);

    // R9 field widths, ignored status writes, unmapped
    bus_wr(8'h0D, 8'hFF); bus_rd(8'h0D, d); check("R9 tx_en width", d, 8'h0F);
    bus_wr(8'h05, 8'hFF); bus_rd(8'h05, d); check("R9 cfg width", d, 8'h01);
    bus_wr(8'h0E, 8'hFF); bus_rd(8'h0E, d); check("R9 tx_st write", d, 0);
    bus_wr(8'h08, 8'hFF); bus_rd(8'h08, d); check("R9 rx_st write", d, 0);
    bus_wr(8'h1D, 8'hFF); bus_rd(8'h1D, d); check("R9 wk_st write", d, 0);
    bus_rd(8'h00, d); check("R9 unmapped", d, 0);
    @(negedge clk); sym_mode = 2'b10;
    pulse(4); pulse(11);
    bus_rd(8'h08, d); check("R9 rx A0 B3 bits", d, 8'h81);

    // R5 event colliding with read stays set
    pulse(1);
    @(negedge clk); rd_en = 1'b1; addr = 8'h0E; tx_evt = 4'b0100;
    @(negedge clk); rd_en = 1'b0; tx_evt = '0; d = rd_data;
    check("R5 read old", d, 8'h02);
    bus_rd(8'h0E, d); check("R5 collision kept", d, 8'h04);

    // R10 read data holds
    bus_rd(8'h0D, d);
    repeat (3) @(negedge clk);
    check("R10 hold", rd_data, 8'h0F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule